// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns a parallel character into an asynchronous serial frame on one output line that rests high. Bit timing comes from a one-cycle enable, `tick`, which pulses at sixteen times the baud rate. Every bit of the frame is held on the line for a fixed number of these ticks. The block needs no baud clock of its own.

The frame format is set at run time through static configuration inputs. The data field can be 5 to 8 bits long. A parity bit can be added and set to even or odd. The stop field can be 1, 1.5 or 2 bit times. A character is offered by pulsing `load` with `din` valid while `ready` is high. `ready` is high only when the transmitter is idle and the far end signals clear-to-send on `cts`. The format in force when a character is accepted is kept for that whole frame, so a frame already on the line always completes.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset, and at any time no frame is in progress, `txd` is 1 and `busy` is 0.
- R2: An accepted frame begins with one start bit at 0, driven from the cycle after acceptance.
- R3: The data field follows the start bit, least significant bit first. Its length is 5 + `cfg_len`: code 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits of `din` above that length are not sent.
- R4: When `cfg_par_en` is 1, a single parity bit follows the data. With `cfg_par_odd` = 0 the number of ones in data plus parity is even. With `cfg_par_odd` = 1 that number is odd. When `cfg_par_en` is 0, no parity bit is sent.
- R5: The stop field is 1 and lasts 16 ticks for `cfg_stop` = 0, 24 ticks for `cfg_stop` = 1, and 32 ticks for `cfg_stop` = 2 or 3.
- R6: The start bit, each data bit and the parity bit each last exactly 16 `tick` pulses, however widely the pulses are spaced. Without a tick, `txd` does not change during a frame.
- R7: `ready` = 1 exactly when no frame is in progress and `cts` = 1. A `load` while `ready` is 1 is accepted, and `busy` is 1 from the next cycle until the clock edge that follows the last stop tick.
- R8: While `cts` is 0, `load` starts no frame: `txd` stays 1 and `busy` stays 0.
- R9: During a frame, `load` pulses and a drop of `cts` are ignored. The frame completes unchanged, and no second frame starts from those pulses.
- R10: The data and configuration are captured at acceptance. Changing `din` or any configuration input during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Enable pulse at 16 times the baud rate |
| load | input | 1 | Offers `din` for transmission |
| din | input | DATA_W | Character to send, LSB first |
| cfg_len | input | 2 | Data length code, length = 5 + code |
| cfg_par_en | input | 1 | Adds a parity bit when 1 |
| cfg_par_odd | input | 1 | 0 even parity, 1 odd parity |
| cfg_stop | input | 2 | Stop length: 0 = 16, 1 = 24, other = 32 ticks |
| cts | input | 1 | Clear-to-send; gates the start of a frame |
| ready | output | 1 | Idle and clear-to-send; `load` will be taken |
| busy | output | 1 | A frame is in progress |
| txd | output | 1 | Serial line, 1 when idle |

## Verification
`busy` is due one clock after the accepting edge, and the start bit appears on `txd` at that same point. The bench drives inputs and samples outputs on the falling edge. It checks `busy` and `ready` on the first falling edge after the accepting one. From then on, every cycle in which the bench raises `tick` is one line slot, and `txd` is compared with the bit the frame formula gives for that slot index. Because `txd` moves only on the edge that consumes a tick, this sampling holds for any tick spacing. The end of the frame is checked on the falling edge after the last stop tick, where `busy` must be 0 and the line must be high.

// File: rtl/sftx_pkg.sv
package sftx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } sftx_state_e;

  typedef struct packed {
    logic [1:0] len;
    logic       par_en;
    logic       par_odd;
    logic [1:0] stop;
  } sftx_cfg_t;

endpackage

// File: rtl/sftx_phase.sv
// Tick counter within one line slot; wraps when the slot limit is reached.
module sftx_phase #(
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          hold,
  input  logic [PW-1:0] limit,
  output logic          wrap
);

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    wrap   = tick && !hold && (cnt_q == limit);
    cnt_en = hold || tick;
    cnt_d  = cnt_q;
    if (hold || wrap) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/sftx_shift.sv
// Holds the character, shifts it out LSB first, and computes parity at load.
module sftx_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [DW-1:0] din,
  input  logic [1:0]    len_code,
  input  logic          par_odd,
  input  logic          shift_en,
  output logic          ser_bit,
  output logic          par_bit
);

  localparam int MINW = DW - 3;

  logic [DW-1:0] keep;
  logic [DW-1:0] sh_q;
  logic [DW-1:0] sh_d;
  logic          par_q;
  logic          par_d;
  logic          sh_en;

  for (genvar i = 0; i < DW; i++) begin : g_keep
    assign keep[i] = (32'(i) < (32'(MINW) + 32'(len_code)));
  end

  always_comb begin
    par_d = (^(din & keep)) ^ par_odd;
    sh_en = load_en || shift_en;
    sh_d  = sh_q;
    if (load_en) begin
      sh_d = din;
    end else if (shift_en) begin
      sh_d = {1'b0, sh_q[DW-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      par_q <= 1'b0;
    end else begin
      if (sh_en) begin
        sh_q <= sh_d;
      end
      if (load_en) begin
        par_q <= par_d;
      end
    end
  end

  assign ser_bit = sh_q[0];
  assign par_bit = par_q;

endmodule

// File: rtl/sftx_ctrl.sv
// Frame sequencer: accept, start, data, parity, stop.
module sftx_ctrl
  import sftx_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16,
  parameter int PW  = 5,
  parameter int BW  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          cts,
  input  sftx_cfg_t     cfg_in,
  input  logic          wrap,
  output sftx_state_e   state,
  output logic          accept,
  output logic          shift_en,
  output logic          hold,
  output logic [PW-1:0] limit,
  output logic          busy,
  output logic          ready
);

  localparam logic [PW-1:0] LIM_BIT  = PW'(OVS - 1);
  localparam logic [PW-1:0] LIM_HALF = PW'(OVS + OVS / 2 - 1);
  localparam logic [PW-1:0] LIM_TWO  = PW'(2 * OVS - 1);
  localparam logic [BW-1:0] LAST_MIN = BW'(DW - 4);

  sftx_state_e   state_q;
  sftx_state_e   state_d;
  sftx_cfg_t     cfg_q;
  sftx_cfg_t     cfg_d;
  logic [BW-1:0] bcnt_q;
  logic [BW-1:0] bcnt_d;
  logic [BW-1:0] last_idx;
  logic [PW-1:0] stop_lim;

  always_comb begin
    last_idx = LAST_MIN + BW'(cfg_q.len);
    unique case (cfg_q.stop)
      2'd0:    stop_lim = LIM_BIT;
      2'd1:    stop_lim = LIM_HALF;
      default: stop_lim = LIM_TWO;
    endcase
  end

  always_comb begin
    ready    = (state_q == ST_IDLE) && cts;
    accept   = ready && load;
    hold     = (state_q == ST_IDLE);
    limit    = (state_q == ST_STOP) ? stop_lim : LIM_BIT;
    state_d  = state_q;
    cfg_d    = cfg_q;
    bcnt_d   = bcnt_q;
    shift_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_START;
          cfg_d   = cfg_in;
        end
      end
      ST_START: begin
        if (wrap) begin
          state_d = ST_DATA;
          bcnt_d  = '0;
        end
      end
      ST_DATA: begin
        if (wrap) begin
          shift_en = 1'b1;
          if (bcnt_q == last_idx) begin
            state_d = cfg_q.par_en ? ST_PAR : ST_STOP;
          end else begin
            bcnt_d = bcnt_q + 1'b1;
          end
        end
      end
      ST_PAR: begin
        if (wrap) begin
          state_d = ST_STOP;
        end
      end
      ST_STOP: begin
        if (wrap) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      bcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        cfg_q <= cfg_d;
      end
      if (wrap) begin
        bcnt_q <= bcnt_d;
      end
    end
  end

  assign state = state_q;
  assign busy  = (state_q != ST_IDLE);

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import sftx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic [1:0]        cfg_stop,
  input  logic              cts,
  output logic              ready,
  output logic              busy,
  output logic              txd
);

  localparam int PW = $clog2(2 * OVERSAMPLE);
  localparam int BW = $clog2(DATA_W);

  sftx_cfg_t     cfg_in;
  sftx_state_e   state;
  logic          accept;
  logic          shift_en;
  logic          hold;
  logic          wrap;
  logic [PW-1:0] limit;
  logic          ser_bit;
  logic          par_bit;

  assign cfg_in = '{len: cfg_len, par_en: cfg_par_en, par_odd: cfg_par_odd, stop: cfg_stop};

  sftx_ctrl #(
    .DW  (DATA_W),
    .OVS (OVERSAMPLE),
    .PW  (PW),
    .BW  (BW)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .cts      (cts),
    .cfg_in   (cfg_in),
    .wrap     (wrap),
    .state    (state),
    .accept   (accept),
    .shift_en (shift_en),
    .hold     (hold),
    .limit    (limit),
    .busy     (busy),
    .ready    (ready)
  );

  sftx_phase #(
    .PW (PW)
  ) u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .hold  (hold),
    .limit (limit),
    .wrap  (wrap)
  );

  sftx_shift #(
    .DW (DATA_W)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (accept),
    .din      (din),
    .len_code (cfg_len),
    .par_odd  (cfg_par_odd),
    .shift_en (shift_en),
    .ser_bit  (ser_bit),
    .par_bit  (par_bit)
  );

  always_comb begin
    unique case (state)
      ST_START: txd = 1'b0;
      ST_DATA:  txd = ser_bit;
      ST_PAR:   txd = par_bit;
      default:  txd = 1'b1;
    endcase
  end

endmodule

// File: rtl/sftx_chk.sv
module sftx_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic load,
  input logic cts,
  input logic ready,
  input logic busy,
  input logic txd
);

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);

  p_stop_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(txd));

  p_no_tick_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(txd));

  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && load) |=> busy);

  p_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (cts && !busy));

  p_cts_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cts) |=> !busy);

endmodule

bind serial_frame_tx sftx_chk u_sftx_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .tick  (tick),
  .load  (load),
  .cts   (cts),
  .ready (ready),
  .busy  (busy),
  .txd   (txd)
);

// File: tb/tb_serial_frame_tx.sv
module tb_serial_frame_tx;

  localparam int CLK_PERIOD = 10;
  localparam int OVS        = 16;
  localparam int WATCHDOG   = 150000;

  logic       clk;
  logic       rst_n;
  logic       tick;
  logic       load;
  logic [7:0] din;
  logic [1:0] cfg_len;
  logic       cfg_par_en;
  logic       cfg_par_odd;
  logic [1:0] cfg_stop;
  logic       cts;
  logic       ready;
  logic       busy;
  logic       txd;

  int checks;
  int fails;
  int cycles;
  bit done;

  serial_frame_tx #(
    .DATA_W     (8),
    .OVERSAMPLE (OVS)
  ) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .load        (load),
    .din         (din),
    .cfg_len     (cfg_len),
    .cfg_par_en  (cfg_par_en),
    .cfg_par_odd (cfg_par_odd),
    .cfg_stop    (cfg_stop),
    .cts         (cts),
    .ready       (ready),
    .busy        (busy),
    .txd         (txd)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG && !done) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int stop_ticks(input logic [1:0] st);
    if (st == 2'd0) return OVS;
    if (st == 2'd1) return OVS + OVS / 2;
    return 2 * OVS;
  endfunction

  // Field of a tick slot: 0 start, 1 data, 2 parity, 3 stop
  function automatic int field_of(input int idx, input int n, input bit pe);
    int b;
    b = idx / OVS;
    if (b == 0) return 0;
    if (b - 1 < n) return 1;
    if (pe && (b - 1 == n)) return 2;
    return 3;
  endfunction

  function automatic logic exp_bit(input int idx, input logic [7:0] d, input int n,
                                   input bit pe, input bit po);
    int  b;
    logic p;
    b = idx / OVS;
    p = po;
    for (int k = 0; k < n; k++) p = p ^ d[k];
    case (field_of(idx, n, pe))
      0:       return 1'b0;
      1:       return d[b-1];
      2:       return p;
      default: return 1'b1;
    endcase
  endfunction

  task automatic run_frame(input logic [7:0] d, input logic [1:0] ln, input bit pe,
                           input bit po, input logic [1:0] st, input int tick_pct,
                           input bit disturb);
    int n;
    int total;
    int idx;
    int err[4];
    int busy_err;
    int fld;
    logic e;
    n     = 5 + int'(ln);
    total = OVS * (1 + n + (pe ? 1 : 0)) + stop_ticks(st);
    foreach (err[i]) err[i] = 0;
    busy_err = 0;
    @(negedge clk);
    tick = 1'b0; din = d; cfg_len = ln; cfg_par_en = pe; cfg_par_odd = po;
    cfg_stop = st; cts = 1'b1; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    chk(busy && !ready, "R7 busy after accept", int'({busy, ready}), 2);
    if (disturb) begin
      // R9 R10: stray load, cts drop and new config during the frame
      load = 1'b1; cts = 1'b0; din = ~d; cfg_len = ~ln; cfg_par_en = ~pe;
      cfg_par_odd = ~po; cfg_stop = ~st;
    end
    idx = 0;
    while (idx < total) begin
      @(negedge clk);
      tick = (($urandom % 100) < tick_pct);
      if (tick) begin
        e   = exp_bit(idx, d, n, pe, po);
        fld = field_of(idx, n, pe);
        if (txd !== e) begin
          if (err[fld] == 0)
            $display("  slot %0d field %0d: txd %0b expected %0b", idx, fld, txd, e);
          err[fld]++;
        end
        if (!busy) busy_err++;
        idx++;
      end
    end
    @(negedge clk);
    tick = 1'b0;
    chk(!busy && txd, "R6 frame ends after exact tick count", int'({busy, txd}), 1);
    load = 1'b0; cts = 1'b1;
    chk(err[0] == 0, "R2 start bit", err[0], 0);
    chk(err[1] == 0, "R3 data field", err[1], 0);
    chk(err[2] == 0, "R4 parity bit", err[2], 0);
    chk(err[3] == 0, "R5 stop field", err[3], 0);
    chk(busy_err == 0, "R7 busy during frame", busy_err, 0);
    if (disturb) begin
      repeat (3) begin
        @(negedge clk);
        chk(!busy && txd, "R9 no frame from stray load", int'({busy, txd}), 1);
      end
    end
  endtask

  initial begin
    checks = 0; fails = 0; cycles = 0; done = 0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; tick = 1'b0; load = 1'b0; din = '0; cfg_len = 2'd3;
    cfg_par_en = 1'b0; cfg_par_odd = 1'b0; cfg_stop = 2'd0; cts = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd && !busy && ready, "R1 reset state", int'({txd, busy, ready}), 5);

    // R8: cts low blocks a load
    cts = 1'b0; load = 1'b1; din = 8'h5A;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      tick = i[0];
      chk(!busy && txd && !ready, "R8 cts low blocks load", int'({busy, txd, ready}), 2);
    end
    load = 1'b0; cts = 1'b1; tick = 1'b0;

    // Directed corners: lengths, parity senses, stop lengths
    run_frame(8'hA5, 2'd3, 1'b0, 1'b0, 2'd0, 100, 1'b0);
    run_frame(8'hFF, 2'd0, 1'b1, 1'b0, 2'd1, 100, 1'b0);
    run_frame(8'h00, 2'd0, 1'b1, 1'b1, 2'd2, 100, 1'b0);
    run_frame(8'h96, 2'd1, 1'b1, 1'b1, 2'd3, 35, 1'b0);
    run_frame(8'h3C, 2'd2, 1'b1, 1'b0, 2'd1, 50, 1'b1);
    run_frame(8'hE1, 2'd3, 1'b1, 1'b1, 2'd2, 100, 1'b1);

    // Random frames
    for (int f = 0; f < 30; f++) begin
      run_frame(8'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
                30 + int'($urandom % 71), (($urandom % 4) == 0));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule